// File: doc/BRIEF.md
# Serial DAC Input Deserializer

This block takes a 16-bit serial frame for a 14-bit two's-complement converter word and turns it into a parallel word. A frame starts when the active-low frame strobe goes low. Data is taken on each of the next sixteen falling edges of the serial clock. All serial and control pins are asynchronous to the block. They pass through a synchronizer into the system clock domain, where the serial clock edges are found by comparing successive samples.

Two mode pins decide how the 14 payload bits sit in the 16 received bits. One pin picks MSB-first or LSB-first order. The other picks whether the two unused bits come at the start or at the end of the frame. A finished word is written to an input register. An active-low load control then decides when the output register takes a new value: on a load falling edge outside a frame, or at the end of a frame if load was low through the end of that frame.

Top module: `sdi_deser`

## Requirements
- R1: After reset, `inWord` and `dacWord` are zero and `frameDone` is low.
- R2: While `syncN` is low, the block counts falling edges of `serClk` and takes `serData` at each one. The 16th edge writes `inWord`, and `frameDone` goes high for exactly one system clock cycle at that write.
- R3: With fmtSel=0 and justSel=0, received bits 1 and 2 are dropped. Bit 3 goes to `inWord[0]` and bit 16 goes to `inWord[13]`, in ascending order.
- R4: With fmtSel=0 and justSel=1, bit 1 goes to `inWord[0]` and bit 14 goes to `inWord[13]`, in ascending order. Bits 15 and 16 are dropped.
- R5: With fmtSel=1 and justSel=0, bits 1 and 2 are dropped. Bit 3 goes to `inWord[13]` and bit 16 goes to `inWord[0]`, in descending order.
- R6: With fmtSel=1 and justSel=1, bit 1 goes to `inWord[13]` and bit 14 goes to `inWord[0]`, in descending order. Bits 15 and 16 are dropped.
- R7: If `syncN` rises before the 16th edge, the partial frame is discarded. `inWord` keeps its old value and no `frameDone` pulse occurs.
- R8: The mode pins are captured when a frame starts. Changing them during the frame has no effect on that frame's word.
- R9: A falling edge of `loadN` outside a frame copies `inWord` into `dacWord`.
- R10: If `loadN` is low for the whole frame, `dacWord` takes the new word on the 16th edge, together with `inWord`.
- R11: A falling edge of `loadN` inside a frame does not change `dacWord` at once. If `loadN` then stays low, `dacWord` takes the new word on the 16th edge.
- R12: If `loadN` rises during a frame, `dacWord` is not updated when that frame ends.
- R13: Falling edges after the 16th, while `syncN` is still low, do not change `inWord` and do not give another `frameDone` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial clock; data is taken on its falling edge |
| syncN | input | 1 | Active-low frame strobe |
| serData | input | 1 | Serial data line |
| loadN | input | 1 | Active-low load control for the output register |
| fmtSel | input | 1 | Bit order: 0 = LSB first, 1 = MSB first |
| justSel | input | 1 | Unused-bit position: 0 = at the start of the frame, 1 = at the end |
| inWord | output | WORD_W | Input register |
| dacWord | output | WORD_W | Output register |
| frameDone | output | 1 | One-cycle pulse when `inWord` is written |

## Verification
The bench builds the block with its default parameters: a 14-bit word, a 16-bit frame and a two-stage synchronizer. The two unused bits and all four placements of the payload window are therefore exercised. The serial clock half-period is six system cycles, which is longer than the synchronizer plus edge-detect latency, so every serial edge is seen once. With these settings the bench reaches several corner cases:
- aborted frames of every length;
- mode pins changed in the middle of a frame;
- extra edges after the 16th;
- the four load timings (high throughout, low throughout, falling mid-frame, falling then rising again).

// File: rtl/sdi_pkg.sv
package sdi_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic startFrame;     // clear the shifter, a frame begins
    logic shiftEn;        // take one serial bit
    logic commitIn;       // write the extracted word to the input register
    logic commitOutNew;   // write the freshly extracted word to the output register
    logic commitOutHeld;  // copy the input register to the output register
  } sdiStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_HOLD = 2'd2
  } sdiState_t;

endpackage

// File: rtl/sdi_sync.sv
module sdi_sync #(
  parameter int            W       = 6,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);

  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= RST_VAL;
          else       chain[s] <= asyncIn;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= RST_VAL;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/sdi_ctrl.sv
module sdi_ctrl
  import sdi_pkg::*;
#(
  parameter int FRAME_LEN = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkLvl,
  input  logic       syncLvl,
  input  logic       loadLvl,
  input  logic       fmtLvl,
  input  logic       justLvl,
  output sdiStrobe_t strobe,
  output logic       modeFmt,
  output logic       modeJust,
  output logic       frameDone
);

  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_LEN - 1);

  sdiState_t        state, nextState;
  logic [CNT_W-1:0] bitCnt;
  logic             prevClk, prevLoad;
  logic             armFlag;
  logic             clkFall, loadFall, loadRise;
  logic             frameOpen;

  assign clkFall   = prevClk & ~clkLvl;
  assign loadFall  = prevLoad & ~loadLvl;
  assign loadRise  = ~prevLoad & loadLvl;
  assign frameOpen = ~syncLvl;

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        strobe.commitOutHeld = loadFall;
        if (frameOpen) begin
          strobe.startFrame = 1'b1;
          nextState         = ST_RECV;
        end
      end
      ST_RECV: begin
        if (!frameOpen) begin
          nextState = ST_IDLE;            // partial frame dropped
        end else if (clkFall) begin
          strobe.shiftEn = 1'b1;
          if (bitCnt == LAST_BIT) begin
            strobe.commitIn     = 1'b1;
            strobe.commitOutNew = armFlag & ~loadLvl;
            nextState           = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        strobe.commitOutHeld = loadFall;
        if (!frameOpen) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      prevClk   <= 1'b1;
      prevLoad  <= 1'b1;
      armFlag   <= 1'b0;
      modeFmt   <= 1'b0;
      modeJust  <= 1'b0;
      frameDone <= 1'b0;
    end else begin
      state     <= nextState;
      prevClk   <= clkLvl;
      prevLoad  <= loadLvl;
      frameDone <= strobe.commitIn;
      if (strobe.startFrame) begin
        bitCnt   <= '0;
        armFlag  <= 1'b1;
        modeFmt  <= fmtLvl;
        modeJust <= justLvl;
      end else begin
        if (strobe.shiftEn) bitCnt <= bitCnt + 1'b1;
        if (state == ST_RECV && loadRise) armFlag <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sdi_dpath.sv
module sdi_dpath
  import sdi_pkg::*;
#(
  parameter int WORD_W    = 14,
  parameter int FRAME_LEN = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  sdiStrobe_t        strobe,
  input  logic              dataBit,
  input  logic              modeFmt,
  input  logic              modeJust,
  output logic [WORD_W-1:0] inWord,
  output logic [WORD_W-1:0] dacWord
);

  logic [FRAME_LEN-1:0] shiftReg, nextShift;
  logic [WORD_W-1:0]    window, newWord;

  always_comb begin
    nextShift = {shiftReg[FRAME_LEN-2:0], dataBit};
    // first received bit ends at the top of the shifter
    window = modeJust ? nextShift[FRAME_LEN-1 -: WORD_W] : nextShift[WORD_W-1:0];
    for (int k = 0; k < WORD_W; k++) begin
      newWord[k] = modeFmt ? window[k] : window[WORD_W-1-k];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      inWord   <= '0;
      dacWord  <= '0;
    end else begin
      if (strobe.startFrame)   shiftReg <= '0;
      else if (strobe.shiftEn) shiftReg <= nextShift;
      if (strobe.commitIn)     inWord   <= newWord;
      if (strobe.commitOutNew)       dacWord <= newWord;
      else if (strobe.commitOutHeld) dacWord <= inWord;
    end
  end

endmodule

// File: rtl/sdi_deser.sv
module sdi_deser
  import sdi_pkg::*;
#(
  parameter int WORD_W      = 14,
  parameter int FRAME_LEN   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              syncN,
  input  logic              serData,
  input  logic              loadN,
  input  logic              fmtSel,
  input  logic              justSel,
  output logic [WORD_W-1:0] inWord,
  output logic [WORD_W-1:0] dacWord,
  output logic              frameDone
);

  localparam int PIN_W = 6;

  logic [PIN_W-1:0] pinSync;
  logic             clkLvl, syncLvl, loadSync, dataLvl, fmtLvl, justLvl;
  sdiStrobe_t       strobe;
  logic             modeFmt, modeJust;

  sdi_sync #(
    .W      (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(6'b111000)
  ) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({serClk, syncN, loadN, serData, fmtSel, justSel}),
    .syncOut(pinSync)
  );

  assign {clkLvl, syncLvl, loadSync, dataLvl, fmtLvl, justLvl} = pinSync;

  sdi_ctrl #(.FRAME_LEN(FRAME_LEN)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .clkLvl   (clkLvl),
    .syncLvl  (syncLvl),
    .loadLvl  (loadSync),
    .fmtLvl   (fmtLvl),
    .justLvl  (justLvl),
    .strobe   (strobe),
    .modeFmt  (modeFmt),
    .modeJust (modeJust),
    .frameDone(frameDone)
  );

  sdi_dpath #(.WORD_W(WORD_W), .FRAME_LEN(FRAME_LEN)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .dataBit (dataLvl),
    .modeFmt (modeFmt),
    .modeJust(modeJust),
    .inWord  (inWord),
    .dacWord (dacWord)
  );

endmodule

// File: rtl/sdi_deser_chk.sv
module sdi_deser_chk #(
  parameter int WORD_W = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameDone,
  input logic [WORD_W-1:0] inWord,
  input logic [WORD_W-1:0] dacWord,
  input logic              loadSync,
  input logic              syncLvl
);

  // R2: completion pulse lasts one cycle
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  // R7: the input register only moves together with a completion pulse
  a_r7_in_only_on_done: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(inWord) |-> frameDone);

  // R10: whenever the output register moves it lands on the input register value
  a_r10_out_tracks_in: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dacWord) |-> (dacWord == inWord));

  // R9: the output register moves only while the synchronized load is low
  a_r9_out_needs_load: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dacWord) |-> !$past(loadSync));

  // R13: completion only while a frame is open
  a_r13_done_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> !$past(syncLvl));

endmodule

bind sdi_deser sdi_deser_chk #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .frameDone(frameDone),
  .inWord   (inWord),
  .dacWord  (dacWord),
  .loadSync (loadSync),
  .syncLvl  (syncLvl)
);

// File: tb/sdi_deser_bench.sv
`timescale 1ns/1ps
module sdi_deser_bench;

  localparam int WORD_W = 14;
  localparam int HALF   = 6;

  logic clk = 1'b0, rstN = 1'b0;
  logic serClk = 1'b1, syncN = 1'b1, serData = 1'b0, loadN = 1'b1;
  logic fmtSel = 1'b0, justSel = 1'b0;
  logic [WORD_W-1:0] inWord, dacWord;
  logic frameDone;

  int checks = 0, fails = 0, doneCnt = 0, doubleDone = 0;
  logic prevDone = 1'b0;
  bit finished = 0;
  logic [WORD_W-1:0] expIn = '0, expDac = '0;

  always #2 clk = ~clk;

  sdi_deser u_sdi_deser (
    .clk(clk), .rstN(rstN), .serClk(serClk), .syncN(syncN), .serData(serData),
    .loadN(loadN), .fmtSel(fmtSel), .justSel(justSel),
    .inWord(inWord), .dacWord(dacWord), .frameDone(frameDone)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (frameDone) begin
        doneCnt++;
        if (prevDone) doubleDone++;
      end
      prevDone = frameDone;
    end
  end

  function automatic logic [WORD_W-1:0] extract(input logic [15:0] fr, input logic f, input logic j);
    logic [WORD_W-1:0] w;
    for (int k = 0; k < WORD_W; k++) begin
      int pos;
      pos = j ? k : k + 2;          // 0-based position in send order
      if (f) w[WORD_W-1-k] = fr[15-pos];
      else   w[k]          = fr[15-pos];
    end
    return w;
  endfunction

  function automatic string modeTag(input logic f, input logic j);
    if (!f && !j) return "R3";
    if (!f &&  j) return "R4";
    if ( f && !j) return "R5";
    return "R6";
  endfunction

  task automatic chk(input string req, input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sendBit(input logic b);
    serData = b;
    serClk  = 1'b1;
    waitCyc(HALF);
    serClk  = 1'b0;
    waitCyc(HALF);
  endtask

  // plan: 0 load high, 1 load low all frame, 2 falls mid-frame, 3 falls then rises
  task automatic runFrame(input logic [15:0] fr, input logic f, input logic j,
                          input int nEdges, input int plan, input int extra, input bit flip);
    int doneAt;
    logic [WORD_W-1:0] oldDac;
    fmtSel = f; justSel = j;
    if (plan == 1) begin
      loadN = 1'b0;
      waitCyc(8);
      expDac = expIn;                 // fall outside a frame
      chk("R9", dacWord, expDac);
    end
    waitCyc(2);
    doneAt = doneCnt;
    oldDac = expDac;
    syncN = 1'b0;
    waitCyc(4);
    for (int i = 0; i < nEdges; i++) begin
      if (flip && i == 7) begin fmtSel = ~f; justSel = ~j; end
      if ((plan == 2 || plan == 3) && i == 5) loadN = 1'b0;
      if (plan == 3 && i == 10) loadN = 1'b1;
      if ((plan == 2 || plan == 3) && i == 8) chk("R11", dacWord, oldDac);
      sendBit(fr[15-i]);
    end
    serClk = 1'b1;
    waitCyc(8);
    if (nEdges == 16) begin
      expIn = extract(fr, f, j);
      if (plan == 1 || plan == 2) expDac = expIn;
      chk(flip ? "R8" : modeTag(f, j), inWord, expIn);
      chk("R2", WORD_W'(doneCnt - doneAt), WORD_W'(1));
      chk(plan == 1 ? "R10" : (plan == 2 ? "R11" : "R12"), dacWord, expDac);
      for (int i = 0; i < extra; i++) sendBit(~fr[i]);
      if (extra > 0) begin
        serClk = 1'b1;
        waitCyc(8);
        chk("R13", inWord, expIn);
        chk("R13", WORD_W'(doneCnt - doneAt), WORD_W'(1));
      end
    end else begin
      chk("R7", inWord, expIn);
      chk("R7", WORD_W'(doneCnt - doneAt), WORD_W'(0));
      chk("R7", dacWord, expDac);
    end
    syncN = 1'b1;
    waitCyc(6);
    loadN = 1'b1;
    fmtSel = f; justSel = j;
    waitCyc(8);
    chk("R12", dacWord, expDac);        // a rise outside a frame changes nothing
  endtask

  task automatic finish();
    if (finished) return;
    finished = 1;
    chk("R2", WORD_W'(doubleDone), WORD_W'(0));
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    waitCyc(150000);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish();
  end

  initial begin
    void'($urandom(32'd4711));
    waitCyc(3);
    chk("R1", inWord, '0);
    chk("R1", dacWord, '0);
    chk("R1", WORD_W'(frameDone), '0);
    rstN = 1'b1;
    waitCyc(4);
    chk("R1", WORD_W'(frameDone), '0);

    // directed: each mode, one-hot and edge patterns
    runFrame(16'h0001, 0, 0, 16, 0, 0, 0);
    runFrame(16'h2000, 0, 0, 16, 0, 0, 0);
    runFrame(16'h8001, 0, 1, 16, 0, 0, 0);
    runFrame(16'h4004, 0, 1, 16, 0, 0, 0);
    runFrame(16'h2001, 1, 0, 16, 0, 0, 0);
    runFrame(16'hC000, 1, 0, 16, 0, 0, 0);
    runFrame(16'h8004, 1, 1, 16, 0, 0, 0);
    runFrame(16'h0003, 1, 1, 16, 0, 0, 0);
    // load held low through frame, mid-frame fall, fall then rise
    runFrame(16'hA5C3, 0, 0, 16, 1, 0, 0);
    runFrame(16'h3C5A, 1, 1, 16, 2, 0, 0);
    runFrame(16'hF00F, 0, 1, 16, 3, 0, 0);
    // load fall outside a frame
    loadN = 1'b0; waitCyc(8);
    expDac = expIn;
    chk("R9", dacWord, expDac);
    loadN = 1'b1; waitCyc(8);
    // mode pins flipped mid-frame, extra edges, aborts
    runFrame(16'h1234, 1, 0, 16, 0, 0, 1);
    runFrame(16'hBEEF, 0, 1, 16, 0, 4, 0);
    runFrame(16'hFFFF, 0, 0, 15, 0, 0, 0);
    runFrame(16'h5555, 1, 1, 1, 0, 0, 0);

    for (int n = 0; n < 45; n++) begin
      logic [15:0] fr;
      int edges, plan;
      fr    = 16'($urandom);
      edges = ($urandom % 6 == 0) ? 1 + int'($urandom % 15) : 16;
      plan  = (edges == 16) ? int'($urandom % 4) : 0;
      runFrame(fr, 1'($urandom), 1'($urandom), edges, plan,
               (edges == 16 && $urandom % 4 == 0) ? 2 : 0, bit'($urandom % 5 == 0));
    end
    finish();
  end

endmodule